// File: doc/BRIEF.md
# Four-Window Priority Compositor

This block picks the colour of every dot of an on-screen character grid. The dot position arrives as a character row and column, plus the dot within the cell and the line within the cell. The block compares that position with four rectangular background windows and with the drop shadow that each window may cast. It then overlays the current character's foreground pixel and background colour on top. It drives a 3-bit RGB value and a fast-blanking signal that tells the downstream video mixer when the overlay replaces the picture.

Window geometry is given in character cells. A window spans whole cells from its start row or column to its end row or column. The drop shadow is the window rectangle moved right by the shadow width and down by the shadow height, in dots and lines. Only the part outside the window itself is drawn. All shadows use one shared colour. Each window's enable bit is held inside the block. It is set or cleared one window at a time, and a single clear command clears all four. The timing generator feeds one dot per clock. Results appear two clocks later: one pipeline stage resolves geometry, the second merges colours and registers the outputs.

Top module: `osdc_compositor`

## Requirements
- R1: After reset `rgb_out` is 0, `blank_out` is 0 and all four window enables are cleared, so a dot inside a configured window shows colour 0.
- R2: A dot with `glyph_bit`=1 shows `fg_rgb`, whatever windows or shadows cover it.
- R3: A dot with `glyph_bit`=0 and `bg_rgb` not equal to 0 shows `bg_rgb`. When `bg_rgb`=000 there is no character background, and the window, the shadow or colour 0 shows through.
- R4: Window index 0 (bits [2:0] of `win_rgb`, bits [3:0] of the row buses, bits [4:0] of the column buses) has the highest priority and index 3 the lowest. Where enabled windows overlap, the colour of the lowest index wins.
- R5: A window whose row start is greater than its row end, or whose column start is greater than its column end, shows neither its body nor its shadow.
- R6: Window i with `win_shd_en[i]`=1 casts a shadow of colour `shd_rgb`. The shadow covers dots x in [x0+W, x1+W] and lines y in [y0+H, y1+H] that lie outside the window's own rectangle. Here x = col*12+dot and y = row*18+line, and x0..x1 and y0..y1 are the window's dot and line extents. The 2-bit width code at `shd_w_code[2i+1:2i]` and the 2-bit height code at `shd_h_code` give W and H: 00 means 2, 01 means 4, 10 means 6 and 11 means 8.
- R7: Any window body has priority over any shadow.
- R8: An enable write (`en_we`=1) sets window `en_idx` to `en_val` from the next dot on. A `clr_win` pulse clears all four enables, and it wins over a write in the same cycle.
- R9: When `blank_char_only`=0, the blanking region is any dot that shows a glyph pixel, a non-zero character background, a window body or a shadow. When `blank_char_only`=1, the region is glyph pixels and non-zero character backgrounds only.
- R10: When `blank_act_hi`=1, `blank_out` is 1 inside the blanking region and 0 outside it. When `blank_act_hi`=0 the levels are inverted.
- R11: When `pix_vld`=0, `rgb_out` is 0 and `blank_out` is at its inactive level.
- R12: `rgb_out` and `blank_out` reflect the inputs presented two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_vld | input | 1 | Current dot lies inside the character grid |
| row_idx | input | 4 | Character row of the current dot |
| col_idx | input | 5 | Character column of the current dot |
| dot_idx | input | 4 | Dot within the cell, 0 to 11 |
| line_idx | input | 5 | Line within the cell, 0 to 17 |
| glyph_bit | input | 1 | Character foreground pixel |
| fg_rgb | input | 3 | Character foreground colour |
| bg_rgb | input | 3 | Character background colour, 000 = none |
| win_row_lo | input | 16 | Start row per window, 4 bits each |
| win_row_hi | input | 16 | End row per window, 4 bits each |
| win_col_lo | input | 20 | Start column per window, 5 bits each |
| win_col_hi | input | 20 | End column per window, 5 bits each |
| win_shd_en | input | 4 | Shadow enable per window |
| win_rgb | input | 12 | Body colour per window, 3 bits each |
| shd_w_code | input | 8 | Shadow width code per window, 2 bits each |
| shd_h_code | input | 8 | Shadow height code per window, 2 bits each |
| shd_rgb | input | 3 | Shared shadow colour |
| en_we | input | 1 | Write strobe for one window enable |
| en_idx | input | 2 | Window selected by the write |
| en_val | input | 1 | Enable value to write |
| clr_win | input | 1 | Clear every window enable |
| blank_char_only | input | 1 | Blanking region limited to characters |
| blank_act_hi | input | 1 | Blanking polarity, 1 = active high |
| rgb_out | output | 3 | Registered dot colour |
| blank_out | output | 1 | Registered fast-blanking output |

## Verification
The layered cases stack a glyph pixel, then a character background, then two overlapping windows, on the same dot, so each priority level is separated from the one below it. Shadow dots are taken one dot or line on each side of the shifted edges, under two width codes and two height codes. These tell an exact offset apart from an off-by-one offset, and a shadow apart from a body. Windows with inverted rows and with inverted columns are tried separately. Enable writes, a clear that coincides with a write, and both blanking modes under both polarities each change only one control, so the output shows which control took effect.

// File: rtl/osdc_pkg.sv
package osdc_pkg;

    localparam int SHD_CODE_W = 2;
    localparam int SPAN_W     = SHD_CODE_W + 2;
    localparam int RGB_W      = 3;

    typedef logic [RGB_W-1:0] rgb_t;

    // Shadow extent in dots or lines: codes 0..3 give 2, 4, 6, 8
    function automatic logic [SPAN_W-1:0] shd_span(input logic [SHD_CODE_W-1:0] code);
        return SPAN_W'({code, 1'b0}) + SPAN_W'(2);
    endfunction

endpackage

// File: rtl/osdc_win_en.sv
module osdc_win_en #(
    parameter int NWIN  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             val,
    input  logic             clr,
    output logic [NWIN-1:0]  en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (clr) begin
            en_q <= '0;
        end else if (we) begin
            en_q[idx] <= val;
        end
    end

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (en_q == '0));

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (en_q[$past(idx)] == $past(val)));

endmodule

// File: rtl/osdc_win_hit.sv
module osdc_win_hit
    import osdc_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int X_W    = 10,
    parameter int Y_W    = 10,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [X_W-1:0]        x,
    input  logic [Y_W-1:0]        y,
    input  logic                  en,
    input  logic                  shd_en,
    input  logic [ROW_W-1:0]      row_lo,
    input  logic [ROW_W-1:0]      row_hi,
    input  logic [COL_W-1:0]      col_lo,
    input  logic [COL_W-1:0]      col_hi,
    input  logic [SHD_CODE_W-1:0] sw_code,
    input  logic [SHD_CODE_W-1:0] sh_code,
    output logic                  body_o,
    output logic                  shd_o
);

    localparam int XE = X_W + 1;
    localparam int YE = Y_W + 1;

    logic [XE-1:0] xw, x_lo, x_hi, sx_lo, sx_hi, sw;
    logic [YE-1:0] yw, y_lo, y_hi, sy_lo, sy_hi, sh;
    logic          geo_ok, in_rect, in_shift;

    always_comb begin
        xw    = XE'(x);
        yw    = YE'(y);
        sw    = XE'(shd_span(sw_code));
        sh    = YE'(shd_span(sh_code));
        x_lo  = XE'(col_lo) * XE'(CELL_W);
        x_hi  = XE'(col_hi) * XE'(CELL_W) + XE'(CELL_W - 1);
        y_lo  = YE'(row_lo) * YE'(CELL_H);
        y_hi  = YE'(row_hi) * YE'(CELL_H) + YE'(CELL_H - 1);
        sx_lo = x_lo + sw;
        sx_hi = x_hi + sw;
        sy_lo = y_lo + sh;
        sy_hi = y_hi + sh;
    end

    always_comb begin
        geo_ok   = en && (row_lo <= row_hi) && (col_lo <= col_hi);
        in_rect  = (xw >= x_lo) && (xw <= x_hi) && (yw >= y_lo) && (yw <= y_hi);
        in_shift = (xw >= sx_lo) && (xw <= sx_hi) && (yw >= sy_lo) && (yw <= sy_hi);
        body_o   = geo_ok && in_rect;
        shd_o    = geo_ok && shd_en && in_shift && !in_rect;
    end

    // R5
    bad_geom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_lo > row_hi) || (col_lo > col_hi)) |-> (!body_o && !shd_o));

    // R6
    body_shd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(body_o && shd_o));

    // R6
    shd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shd_en |-> !shd_o);

endmodule

// File: rtl/osdc_merge.sv
module osdc_merge
    import osdc_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                  vld,
    input  logic                  glyph,
    input  rgb_t                  fg,
    input  rgb_t                  bg,
    input  logic [NWIN-1:0]       body,
    input  logic                  shd_any,
    input  logic [NWIN*RGB_W-1:0] win_rgb,
    input  rgb_t                  shd_rgb,
    input  logic                  char_only,
    input  logic                  act_hi,
    output rgb_t                  rgb,
    output logic                  blank
);

    rgb_t win_c;
    logic char_zone, win_zone, active;

    // Lowest index is visited last, so it takes the dot
    always_comb begin
        win_c = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (body[i]) begin
                win_c = win_rgb[i*RGB_W +: RGB_W];
            end
        end
    end

    always_comb begin
        rgb = '0;
        if (vld) begin
            if (glyph) begin
                rgb = fg;
            end else if (bg != '0) begin
                rgb = bg;
            end else if (|body) begin
                rgb = win_c;
            end else if (shd_any) begin
                rgb = shd_rgb;
            end
        end
    end

    always_comb begin
        char_zone = glyph || (bg != '0);
        win_zone  = (|body) || shd_any;
        active    = vld && (char_zone || (!char_only && win_zone));
        blank     = act_hi ? active : !active;
    end

endmodule

// File: rtl/osdc_compositor.sv
module osdc_compositor
    import osdc_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int DOT_W  = 4,
    parameter int LINE_W = 5,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pix_vld,
    input  logic [ROW_W-1:0]           row_idx,
    input  logic [COL_W-1:0]           col_idx,
    input  logic [DOT_W-1:0]           dot_idx,
    input  logic [LINE_W-1:0]          line_idx,
    input  logic                       glyph_bit,
    input  logic [2:0]                 fg_rgb,
    input  logic [2:0]                 bg_rgb,
    input  logic [NWIN*ROW_W-1:0]      win_row_lo,
    input  logic [NWIN*ROW_W-1:0]      win_row_hi,
    input  logic [NWIN*COL_W-1:0]      win_col_lo,
    input  logic [NWIN*COL_W-1:0]      win_col_hi,
    input  logic [NWIN-1:0]            win_shd_en,
    input  logic [NWIN*3-1:0]          win_rgb,
    input  logic [NWIN*2-1:0]          shd_w_code,
    input  logic [NWIN*2-1:0]          shd_h_code,
    input  logic [2:0]                 shd_rgb,
    input  logic                       en_we,
    input  logic [$clog2(NWIN)-1:0]    en_idx,
    input  logic                       en_val,
    input  logic                       clr_win,
    input  logic                       blank_char_only,
    input  logic                       blank_act_hi,
    output logic [2:0]                 rgb_out,
    output logic                       blank_out
);

    localparam int IDX_W = $clog2(NWIN);
    localparam int X_W   = $clog2((2**COL_W) * CELL_W) + 1;
    localparam int Y_W   = $clog2((2**ROW_W) * CELL_H) + 1;

    // ---------------- stage 0: dot coordinates and window hits
    logic [X_W-1:0]  pix_x;
    logic [Y_W-1:0]  pix_y;
    logic [NWIN-1:0] win_en;
    logic [NWIN-1:0] hit_body, hit_shd;

    assign pix_x = X_W'(col_idx) * X_W'(CELL_W) + X_W'(dot_idx);
    assign pix_y = Y_W'(row_idx) * Y_W'(CELL_H) + Y_W'(line_idx);

    osdc_win_en #(
        .NWIN  (NWIN),
        .IDX_W (IDX_W)
    ) en_regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (en_we),
        .idx   (en_idx),
        .val   (en_val),
        .clr   (clr_win),
        .en_q  (win_en)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        osdc_win_hit #(
            .ROW_W  (ROW_W),
            .COL_W  (COL_W),
            .X_W    (X_W),
            .Y_W    (Y_W),
            .CELL_W (CELL_W),
            .CELL_H (CELL_H)
        ) hit_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .x       (pix_x),
            .y       (pix_y),
            .en      (win_en[g]),
            .shd_en  (win_shd_en[g]),
            .row_lo  (win_row_lo[g*ROW_W +: ROW_W]),
            .row_hi  (win_row_hi[g*ROW_W +: ROW_W]),
            .col_lo  (win_col_lo[g*COL_W +: COL_W]),
            .col_hi  (win_col_hi[g*COL_W +: COL_W]),
            .sw_code (shd_w_code[g*SHD_CODE_W +: SHD_CODE_W]),
            .sh_code (shd_h_code[g*SHD_CODE_W +: SHD_CODE_W]),
            .body_o  (hit_body[g]),
            .shd_o   (hit_shd[g])
        );
    end

    // ---------------- stage 1 registers
    logic                  s1_vld, s1_glyph, s1_shd, s1_char_only, s1_act_hi;
    rgb_t                  s1_fg, s1_bg, s1_shd_rgb;
    logic [NWIN-1:0]       s1_body;
    logic [NWIN*RGB_W-1:0] s1_win_rgb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld       <= 1'b0;
            s1_glyph     <= 1'b0;
            s1_fg        <= '0;
            s1_bg        <= '0;
            s1_body      <= '0;
            s1_shd       <= 1'b0;
            s1_win_rgb   <= '0;
            s1_shd_rgb   <= '0;
            s1_char_only <= 1'b0;
            s1_act_hi    <= 1'b1;
        end else begin
            s1_vld       <= pix_vld;
            s1_glyph     <= glyph_bit;
            s1_fg        <= fg_rgb;
            s1_bg        <= bg_rgb;
            s1_body      <= hit_body;
            s1_shd       <= |hit_shd;
            s1_win_rgb   <= win_rgb;
            s1_shd_rgb   <= shd_rgb;
            s1_char_only <= blank_char_only;
            s1_act_hi    <= blank_act_hi;
        end
    end

    // ---------------- stage 2: merge and output registers
    rgb_t mix_rgb;
    logic mix_blank;

    osdc_merge #(
        .NWIN (NWIN)
    ) merge_i (
        .vld       (s1_vld),
        .glyph     (s1_glyph),
        .fg        (s1_fg),
        .bg        (s1_bg),
        .body      (s1_body),
        .shd_any   (s1_shd),
        .win_rgb   (s1_win_rgb),
        .shd_rgb   (s1_shd_rgb),
        .char_only (s1_char_only),
        .act_hi    (s1_act_hi),
        .rgb       (mix_rgb),
        .blank     (mix_blank)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_out   <= '0;
            blank_out <= 1'b0;
        end else begin
            rgb_out   <= mix_rgb;
            blank_out <= mix_blank;
        end
    end

    // R2
    glyph_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_glyph) |=> (rgb_out == $past(s1_fg)));

    // R4
    top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_glyph && (s1_bg == '0) && s1_body[0])
            |=> (rgb_out == $past(s1_win_rgb[RGB_W-1:0])));

    // R11
    outside_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> ((rgb_out == '0) && (blank_out == !$past(s1_act_hi))));

    // R9
    char_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_char_only && !s1_glyph && (s1_bg == '0))
            |=> (blank_out == !$past(s1_act_hi)));

endmodule

// File: tb/osdc_compositor_tb.sv
module osdc_compositor_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         due;
        logic [2:0] rgb;
        logic       blank;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_vld = 1'b0;
    logic [3:0]  row_idx = '0;
    logic [4:0]  col_idx = '0;
    logic [3:0]  dot_idx = '0;
    logic [4:0]  line_idx = '0;
    logic        glyph_bit = 1'b0;
    logic [2:0]  fg_rgb = '0;
    logic [2:0]  bg_rgb = '0;
    logic [15:0] win_row_lo = '0;
    logic [15:0] win_row_hi = '0;
    logic [19:0] win_col_lo = '0;
    logic [19:0] win_col_hi = '0;
    logic [3:0]  win_shd_en = '0;
    logic [11:0] win_rgb = '0;
    logic [7:0]  shd_w_code = '0;
    logic [7:0]  shd_h_code = '0;
    logic [2:0]  shd_rgb = '0;
    logic        en_we = 1'b0;
    logic [1:0]  en_idx = '0;
    logic        en_val = 1'b0;
    logic        clr_win = 1'b0;
    logic        blank_char_only = 1'b0;
    logic        blank_act_hi = 1'b1;
    logic [2:0]  rgb_out;
    logic        blank_out;

    osdc_compositor dut_i (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld),
        .row_idx(row_idx), .col_idx(col_idx), .dot_idx(dot_idx), .line_idx(line_idx),
        .glyph_bit(glyph_bit), .fg_rgb(fg_rgb), .bg_rgb(bg_rgb),
        .win_row_lo(win_row_lo), .win_row_hi(win_row_hi),
        .win_col_lo(win_col_lo), .win_col_hi(win_col_hi),
        .win_shd_en(win_shd_en), .win_rgb(win_rgb),
        .shd_w_code(shd_w_code), .shd_h_code(shd_h_code), .shd_rgb(shd_rgb),
        .en_we(en_we), .en_idx(en_idx), .en_val(en_val), .clr_win(clr_win),
        .blank_char_only(blank_char_only), .blank_act_hi(blank_act_hi),
        .rgb_out(rgb_out), .blank_out(blank_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    logic en_m [4];
    exp_t sb_q [$];
    exp_t mon_e;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items when they fall due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            mon_e = sb_q.pop_front();
            n_cmp++;
            if (rgb_out !== mon_e.rgb || blank_out !== mon_e.blank) begin
                n_bad++;
                $display("FAIL %s: got rgb=%0d blank=%0d, expected rgb=%0d blank=%0d",
                         mon_e.tag, rgb_out, blank_out, mon_e.rgb, mon_e.blank);
            end
        end
    end

    task automatic check_now(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    // Expected result built from the requirements
    function automatic logic [3:0] model(input logic vld, input int row, input int col,
                                         input int dot, input int line, input logic g,
                                         input logic [2:0] fg, input logic [2:0] bg);
        int x = col * 12 + dot;
        int y = row * 18 + line;
        logic body_any = 1'b0;
        logic shd = 1'b0;
        logic [2:0] wc = '0;
        logic [2:0] c = '0;
        logic act;
        for (int i = 0; i < 4; i++) begin
            int rl = int'(win_row_lo[i*4 +: 4]);
            int rh = int'(win_row_hi[i*4 +: 4]);
            int cl = int'(win_col_lo[i*5 +: 5]);
            int ch = int'(win_col_hi[i*5 +: 5]);
            int w  = 2 * (int'(shd_w_code[i*2 +: 2]) + 1);
            int h  = 2 * (int'(shd_h_code[i*2 +: 2]) + 1);
            int x0 = cl * 12;
            int x1 = ch * 12 + 11;
            int y0 = rl * 18;
            int y1 = rh * 18 + 17;
            logic ok = en_m[i] && rl <= rh && cl <= ch;
            logic inr = x >= x0 && x <= x1 && y >= y0 && y <= y1;
            logic ins = x >= x0 + w && x <= x1 + w && y >= y0 + h && y <= y1 + h;
            if (ok && inr && !body_any) begin
                body_any = 1'b1;
                wc = win_rgb[i*3 +: 3];
            end
            if (ok && win_shd_en[i] && ins && !inr) shd = 1'b1;
        end
        if (!vld)            c = '0;
        else if (g)          c = fg;
        else if (bg != '0)   c = bg;
        else if (body_any)   c = wc;
        else if (shd)        c = shd_rgb;
        act = vld && (g || bg != '0 || (!blank_char_only && (body_any || shd)));
        return {blank_act_hi ? act : !act, c};
    endfunction

    // Driver: one dot per clock, called at a falling edge
    task automatic pix(input string tag, input logic vld, input int row, input int col,
                       input int dot, input int line, input logic g,
                       input logic [2:0] fg, input logic [2:0] bg);
        exp_t e;
        logic [3:0] m;
        pix_vld   = vld;
        row_idx   = 4'(row);
        col_idx   = 5'(col);
        dot_idx   = 4'(dot);
        line_idx  = 5'(line);
        glyph_bit = g;
        fg_rgb    = fg;
        bg_rgb    = bg;
        m = model(vld, row, col, dot, line, g, fg, bg);
        e.due   = cyc + 2;
        e.rgb   = m[2:0];
        e.blank = m[3];
        e.tag   = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Same as pix, but also states the literal value worked out by hand
    task automatic pix_lit(input string tag, input int row, input int col, input int dot,
                           input int line, input logic [2:0] want);
        logic [3:0] m;
        m = model(1'b1, row, col, dot, line, 1'b0, 3'd0, 3'd0);
        check_now(m[2:0] == want, {tag, " hand value"}, int'(m[2:0]), int'(want));
        pix(tag, 1'b1, row, col, dot, line, 1'b0, 3'd0, 3'd0);
    endtask

    task automatic en_write(input int idx, input logic val, input logic clr);
        en_we   = 1'b1;
        en_idx  = 2'(idx);
        en_val  = val;
        clr_win = clr;
        pix_vld = 1'b0;
        @(negedge clk);
        en_we   = 1'b0;
        clr_win = 1'b0;
        if (clr) begin
            for (int i = 0; i < 4; i++) en_m[i] = 1'b0;
        end else begin
            en_m[idx] = val;
        end
    endtask

    task automatic set_win(input int i, input int rl, input int rh, input int cl,
                           input int ch, input logic [2:0] c);
        win_row_lo[i*4 +: 4] = 4'(rl);
        win_row_hi[i*4 +: 4] = 4'(rh);
        win_col_lo[i*5 +: 5] = 5'(cl);
        win_col_hi[i*5 +: 5] = 5'(ch);
        win_rgb[i*3 +: 3]    = c;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: got no finish, expected end of run");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) en_m[i] = 1'b0;
        set_win(0, 2, 4, 3, 8, 3'd1);
        set_win(1, 3, 6, 6, 12, 3'd2);
        set_win(2, 0, 1, 0, 2, 3'd3);
        set_win(3, 8, 5, 0, 3, 3'd4);
        win_shd_en = 4'b0001;
        shd_w_code = 8'b00_00_00_01;
        shd_h_code = 8'b00_00_00_10;
        shd_rgb    = 3'd5;

        repeat (3) @(negedge clk);
        // R1: reset state
        check_now(rgb_out == 3'd0, "R1 rgb in reset", int'(rgb_out), 0);
        check_now(blank_out == 1'b0, "R1 blank in reset", int'(blank_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: enables cleared, so a configured window is invisible
        pix_lit("R1 window off after reset", 3, 4, 0, 0, 3'd0);

        for (int i = 0; i < 4; i++) en_write(i, 1'b1, 1'b0);

        // R8: enables now on; R4 priority
        pix_lit("R8 window 0 enabled", 2, 4, 0, 0, 3'd1);
        pix_lit("R4 overlap, index 0 wins", 3, 7, 0, 0, 3'd1);
        pix_lit("R4 window 1 alone", 5, 7, 0, 0, 3'd2);
        pix_lit("R4 window 2 alone", 0, 1, 5, 5, 3'd3);

        // R2, R3 layered on a window dot
        pix("R2 glyph over window", 1'b1, 3, 7, 0, 0, 1'b1, 3'd6, 3'd7);
        pix("R3 char background over window", 1'b1, 3, 7, 0, 0, 1'b0, 3'd6, 3'd7);
        pix("R3 zero background lets window through", 1'b1, 3, 7, 0, 0, 1'b0, 3'd6, 3'd0);
        pix("R3 background on empty dot", 1'b1, 14, 29, 0, 0, 1'b0, 3'd0, 3'd2);

        // R5: inverted rows on window 3
        pix_lit("R5 inverted rows hidden", 6, 1, 0, 0, 3'd0);

        // R6: shadow edges (width 4, height 6)
        pix_lit("R6 shadow bottom strip", 5, 3, 5, 0, 3'd5);
        pix_lit("R6 left of shadow", 5, 3, 3, 0, 3'd0);
        pix_lit("R6 last shadow line", 5, 3, 5, 5, 3'd5);
        pix_lit("R6 below shadow", 5, 3, 5, 6, 3'd0);
        pix_lit("R6 right strip", 2, 9, 3, 6, 3'd5);
        pix_lit("R6 right of shadow", 2, 9, 4, 6, 3'd0);
        pix_lit("R6 above right strip", 2, 9, 3, 5, 3'd0);
        // R7: shadow falls inside window 1 body
        pix_lit("R7 body beats shadow", 3, 9, 0, 0, 3'd2);

        // R6: other codes (width 8, height 2)
        shd_w_code = 8'b00_00_00_11;
        shd_h_code = 8'b00_00_00_00;
        pix_lit("R6 width code 11 reaches +8", 2, 9, 7, 6, 3'd5);
        pix_lit("R6 width code 11 ends", 2, 9, 8, 6, 3'd0);
        pix_lit("R6 height code 00 reaches +2", 5, 3, 9, 1, 3'd5);
        pix_lit("R6 height code 00 ends", 5, 3, 9, 2, 3'd0);

        // R5: inverted columns on window 2
        set_win(2, 0, 1, 5, 2, 3'd3);
        pix_lit("R5 inverted columns hidden", 0, 1, 5, 5, 3'd0);
        pix_lit("R5 inverted columns hidden mid", 0, 3, 0, 0, 3'd0);

        // R9 / R10 blanking modes
        pix("R9 window in blank region", 1'b1, 5, 7, 0, 0, 1'b0, 3'd0, 3'd0);
        blank_char_only = 1'b1;
        pix("R9 char-only mode ignores window", 1'b1, 5, 7, 0, 0, 1'b0, 3'd0, 3'd0);
        pix("R9 char-only mode glyph", 1'b1, 5, 7, 0, 0, 1'b1, 3'd4, 3'd0);
        pix("R9 char-only mode background", 1'b1, 5, 7, 0, 0, 1'b0, 3'd0, 3'd1);
        blank_act_hi = 1'b0;
        pix("R10 active-low glyph", 1'b1, 5, 7, 0, 0, 1'b1, 3'd4, 3'd0);
        pix("R10 active-low idle", 1'b1, 10, 20, 0, 0, 1'b0, 3'd0, 3'd0);
        blank_char_only = 1'b0;
        pix("R10 active-low shadow", 1'b1, 5, 3, 9, 1, 1'b0, 3'd0, 3'd0);
        // R11: outside grid
        pix("R11 invalid dot active-low", 1'b0, 3, 7, 0, 0, 1'b1, 3'd7, 3'd7);
        blank_act_hi = 1'b1;
        pix("R11 invalid dot active-high", 1'b0, 3, 7, 0, 0, 1'b1, 3'd7, 3'd7);

        // R12: back-to-back dots keep their order and 2-cycle delay
        pix("R12 stream a", 1'b1, 3, 7, 0, 0, 1'b1, 3'd1, 3'd0);
        pix("R12 stream b", 1'b1, 3, 7, 0, 0, 1'b1, 3'd2, 3'd0);
        pix("R12 stream c", 1'b1, 3, 7, 0, 0, 1'b0, 3'd0, 3'd0);

        // R8: clear wins over same-cycle write
        en_write(1, 1'b1, 1'b1);
        pix_lit("R8 clear removes window 0", 2, 4, 0, 0, 3'd0);
        pix_lit("R8 clear beats write to window 1", 5, 7, 0, 0, 3'd0);
        en_write(1, 1'b1, 1'b0);
        pix_lit("R8 window 1 re-enabled", 5, 7, 0, 0, 3'd2);
        pix_lit("R8 window 0 still off", 2, 4, 0, 0, 3'd0);
        en_write(1, 1'b0, 1'b0);
        pix_lit("R8 window 1 disabled by write", 5, 7, 0, 0, 3'd0);

        pix_vld = 1'b0;
        repeat (4) @(negedge clk);
        check_now(sb_q.size() == 0, "R12 all results drained", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule